// File: doc/BRIEF.md
# Key-Guarded Pin Function Select

This block protects the per-pin function-select vector that feeds a pin multiplexer. The protection has two stages. A guard register has to receive one fixed 32-bit key before the permit mask can be rewritten. The permit mask then decides, bit by bit, which select bits a later write may change. Pins whose permit bit is 0 keep their function even if software writes the select register by mistake.

Software reaches all three registers over a single-cycle register bus. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`. The select vector also drives the pin mux directly through its own output.

Top module: `pin_func_guard`

## Requirements
- R1: After reset the guard reads 1 (locked), the permit mask reads all ones over the PINS low bits, and the select register and `mux_sel` are 0.
- R2: A write of exactly KEY (default 0x0ACCE551) to the guard offset (default 0x520) unlocks it, and the guard then reads 0.
- R3: A guard write of any value other than KEY, including values one bit away from KEY and 0, locks it, and the guard then reads 1.
- R4: A permit-mask write (offset default 0x524) made while locked leaves the mask unchanged.
- R5: A permit-mask write made while unlocked stores the low PINS bits of `wdata`. The upper read bits are 0.
- R6: A write to the select offset (default 0x420) changes only the bits whose permit bit is 1. Every other bit keeps its value.
- R7: `mux_sel` always equals the value read back from the select offset.
- R8: The unlocked state persists through permit, select and unmapped writes, and changes only when the guard register is written.
- R9: Reads of any other offset return 0, and writes to such offsets change no register.
- R10: The select register holds PINS bits. Upper `wdata` bits are discarded and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | AW | Byte offset of the access |
| wdata | input | DW | Write data |
| rdata | output | DW | Combinational read data for `addr` |
| mux_sel | output | PINS | Function-select vector to the pin mux |

## Verification
The bench builds the block with its defaults: PINS=8, a 12-bit offset and a 32-bit data word. With eight pins, permit masks that split the vector into nibbles are easy to build, so per-bit gating can be checked against both kept and changed bits. The 32-bit word also lets the bench write near-miss keys (single-bit flips, a truncated key) and upper-bit garbage into the 8-bit registers.

// File: rtl/pin_func_guard.sv
module pin_func_guard #(
  parameter int PINS = 8,
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY = 32'h0ACC_E551,
  parameter logic [AW-1:0] SEL_OFS = 12'h420,
  parameter logic [AW-1:0] LOCK_OFS = 12'h520,
  parameter logic [AW-1:0] PERMIT_OFS = 12'h524
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [PINS-1:0] mux_sel
);
  localparam int PAD = DW - PINS;

  logic            locked_q;
  logic [PINS-1:0] permit_q;
  logic [PINS-1:0] sel_q;

  wire hit_sel    = addr == SEL_OFS;
  wire hit_lock   = addr == LOCK_OFS;
  wire hit_permit = addr == PERMIT_OFS;
  wire [PINS-1:0] wbits = wdata[PINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      permit_q <= '1;
      sel_q    <= '0;
    end else if (wr_en) begin
      if (hit_lock)
        locked_q <= (wdata != KEY);
      if (hit_permit && !locked_q)
        permit_q <= wbits;
      if (hit_sel)
        sel_q <= (sel_q & ~permit_q) | (wbits & permit_q);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_sel)         rdata = {{PAD{1'b0}}, sel_q};
    else if (hit_lock)   rdata = {{(DW-1){1'b0}}, locked_q};
    else if (hit_permit) rdata = {{PAD{1'b0}}, permit_q};
  end

  assign mux_sel = sel_q;
endmodule

// File: rtl/pin_func_guard_chk.sv
module pin_func_guard_chk #(
  parameter int PINS = 8,
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY = 32'h0ACC_E551,
  parameter logic [AW-1:0] SEL_OFS = 12'h420,
  parameter logic [AW-1:0] LOCK_OFS = 12'h520,
  parameter logic [AW-1:0] PERMIT_OFS = 12'h524
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [PINS-1:0] mux_sel,
  input logic            locked_q,
  input logic [PINS-1:0] permit_q
);
  wire lock_wr   = wr_en && addr == LOCK_OFS;
  wire permit_wr = wr_en && addr == PERMIT_OFS;
  wire unmapped  = addr != SEL_OFS && addr != LOCK_OFS && addr != PERMIT_OFS;

  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr && wdata == KEY |=> !locked_q);

  a_r3_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr && wdata != KEY |=> locked_q);

  a_r4_permit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    permit_wr && locked_q |=> $stable(permit_q));

  a_r6_gated_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mux_sel ^ $past(mux_sel)) & ~$past(permit_q)) == '0);

  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_wr |=> $stable(locked_q));

  a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && unmapped |=> $stable(mux_sel) && $stable(permit_q) && $stable(locked_q));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> rdata == '0);
endmodule

bind pin_func_guard pin_func_guard_chk #(
  .PINS(PINS), .AW(AW), .DW(DW), .KEY(KEY),
  .SEL_OFS(SEL_OFS), .LOCK_OFS(LOCK_OFS), .PERMIT_OFS(PERMIT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .mux_sel(mux_sel), .locked_q(locked_q), .permit_q(permit_q)
);

// File: tb/sim_pin_func_guard.sv
`timescale 1ns/1ps
module sim_pin_func_guard;
  localparam logic [11:0] SEL = 12'h420, LCK = 12'h520, PRM = 12'h524;
  localparam logic [31:0] KEYV = 32'h0ACC_E551;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] mux_sel;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pin_func_guard u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .mux_sel(mux_sel));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic expect_reg(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 lock", LCK, 1);
    expect_reg("R1 permit", PRM, 32'hFF);
    expect_reg("R1 select", SEL, 0);
    check("R1 mux_sel", {24'h0, mux_sel}, 0);
  endtask

  task automatic t_keys;
    wr(LCK, KEYV);            expect_reg("R2 unlock", LCK, 0);
    wr(LCK, KEYV ^ 32'h1);    expect_reg("R3 lsb flip", LCK, 1);
    wr(LCK, KEYV);            expect_reg("R2 unlock again", LCK, 0);
    wr(LCK, KEYV ^ 32'h8000_0000); expect_reg("R3 msb flip", LCK, 1);
    wr(LCK, 32'h0000_0551);   expect_reg("R3 partial key", LCK, 1);
    wr(LCK, KEYV);
    wr(LCK, 0);               expect_reg("R3 zero", LCK, 1);
  endtask

  task automatic t_permit;
    wr(PRM, 32'h0);           expect_reg("R4 locked write", PRM, 32'hFF);
    wr(LCK, KEYV);
    wr(PRM, 32'hABCD_120F);   expect_reg("R5 unlocked write", PRM, 32'h0F);
    expect_reg("R8 still unlocked", LCK, 0);
    wr(LCK, 32'h1234);
    wr(PRM, 32'hF0);          expect_reg("R4 relocked write", PRM, 32'h0F);
  endtask

  task automatic t_select;
    wr(LCK, KEYV); wr(PRM, 32'hFF); wr(LCK, 0);
    wr(SEL, 32'hFFFF_FFA5);   expect_reg("R10 upper dropped", SEL, 32'hA5);
    check("R7 mux_sel", {24'h0, mux_sel}, 32'hA5);
    wr(LCK, KEYV); wr(PRM, 32'h0F);
    wr(SEL, 32'hFF);          expect_reg("R6 low nibble", SEL, 32'hAF);
    check("R7 mux_sel", {24'h0, mux_sel}, 32'hAF);
    wr(SEL, 32'h00);          expect_reg("R6 high kept", SEL, 32'hA0);
    wr(PRM, 32'h00);
    wr(SEL, 32'h5F);          expect_reg("R6 none permitted", SEL, 32'hA0);
    check("R7 mux_sel", {24'h0, mux_sel}, 32'hA0);
    expect_reg("R8 unlocked after writes", LCK, 0);
  endtask

  task automatic t_unmapped;
    wr(12'h424, 32'hFF);      expect_reg("R9 read 424", 12'h424, 0);
    wr(12'h000, 32'hFF);      expect_reg("R9 read 000", 12'h000, 0);
    wr(12'h521, KEYV);        expect_reg("R9 read 521", 12'h521, 0);
    expect_reg("R9 select kept", SEL, 32'hA0);
    expect_reg("R9 permit kept", PRM, 32'h00);
    expect_reg("R8 lock kept", LCK, 0);
    wr(LCK, 32'hDEAD);
    wr(12'h528, KEYV);        expect_reg("R9 no unlock via other offset", LCK, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_keys();
    t_permit();
    t_select();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule